// File: doc/BRIEF.md
# CAN Fault-Confinement Counters with Test Overrides

This block keeps the two error counters of a CAN node, one for transmission and one for reception, and derives from them the node's fault-confinement state: error active, error passive or bus off. The protocol engine feeds it single-cycle event strobes for transmit errors, transmit successes, receive errors (weight 1 or weight 8) and receive successes. The block updates both counters one clock after each strobe.

A 16-bit control register sits on a small register bus. Its top bit turns on test mode. Under test mode, one bit opens a joint load path that writes a single 8-bit value into both counters, but only while the node is halted. Another bit forces error-passive behaviour whatever the counts are. A loaded value can never exceed 255, so software cannot use the load path to drive the node into bus off.

Registers are at word address 0 (control) and word address 1 (counters). Reads are combinational from the register state. Writes take effect at the next rising clock edge.

Top module: `can_fault_conf`

## Requirements
- R1: Reset clears every control bit and both counters. A write to address 0 stores write-data bits 15..8 into control bits 15..8. Control bits 7..0 always read 0. Bits 12..8 read back as written and have no other effect. Reading address 0 returns the control register.
- R2: A write to address 1 loads write-data bits 7..0 into both counters at the next edge. This happens only when control bit 15 is 1, control bit 14 is 1 and halt_i is 1. In every other case the write changes neither counter.
- R3: Write-data bits 15..8 of a counter load are ignored. A load always leaves the transmit counter at 255 or below, so a load never produces bus off. A load made while the node is in bus off returns it to counting from the loaded value.
- R4: Error passive is forced only when both control bit 15 and control bit 13 are 1. With either of them at 0, the state follows the counters.
- R5: A transmit-error strobe adds 8 to the transmit counter. A transmit-success strobe subtracts 1, but not below 0. When both strobes arrive in the same cycle, the error wins.
- R6: When a transmit error would take the transmit counter above 255, the counter becomes 256 and bus_off_o rises. While bus off holds, transmit events leave the counter at 256. Only reset or a counter load (R3) ends bus off.
- R7: The receive counter responds to three strobes, in priority order rx_err8_i, then rx_err1_i, then rx_ok_i. rx_err8_i adds 8 and rx_err1_i adds 1, with the result saturating at 255. rx_ok_i subtracts 1, but not below 0. The receive counter keeps counting during bus off.
- R8: Exactly one of err_active_o, err_passive_o and bus_off_o is 1. Bus off overrides everything. Otherwise the node is passive when either counter is 128 or more, or when passive is forced (R4). In all remaining cases it is active.
- R9: When a counter load and event strobes fall in the same cycle, the load sets both counters and the strobes are lost.
- R10: Reading address 1 returns the receive counter in bits 15..8 and the transmit counter in bits 7..0, with the transmit count shown as 255 during bus off. Addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_err_i | input | 1 | Transmit error strobe |
| tx_ok_i | input | 1 | Transmit success strobe |
| rx_err1_i | input | 1 | Receive error strobe, weight 1 |
| rx_err8_i | input | 1 | Receive error strobe, weight 8 |
| rx_ok_i | input | 1 | Receive success strobe |
| halt_i | input | 1 | Node is in halt mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| tec_o | output | 9 | Transmit error counter (256 = bus off) |
| rec_o | output | 8 | Receive error counter |
| err_active_o | output | 1 | Node is error active |
| err_passive_o | output | 1 | Node is error passive |
| bus_off_o | output | 1 | Node is bus off |

## Verification
The bench sweeps every loadable value and every combination of the three test bits together with halt. This would expose a load path that ignores halt or the master bit, and a forced passive that works without test mode. It steps the transmit counter through all 32 increments up to bus off and then keeps issuing events. A design that wrapped the counter, or left bus off on a success strobe, would show a wrong count or flag there. It also drives the receive counter into 255 and down through 0, and probes the 127/128 thresholds on both counters. Finally, it fires loads together with strobes in the same cycle, where a design that applied the strobe after the load would be off by one or eight.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    localparam int CTRL_W    = 16;
    localparam int BIT_TEST  = 15;
    localparam int BIT_CNTWR = 14;
    localparam int BIT_FORCE = 13;
    localparam int KEEP_LO   = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CNT  = 2'd1,
        ADDR_RSV2 = 2'd2,
        ADDR_RSV3 = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/can_fc_ctrl_reg.sv
module can_fc_ctrl_reg #(
    parameter int CTRL_W    = 16,
    parameter int KEEP_LO   = 8,
    parameter int BIT_TEST  = 15,
    parameter int BIT_CNTWR = 14,
    parameter int BIT_FORCE = 13
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_i,
    input  logic [CTRL_W-1:KEEP_LO]   wdata_i,
    output logic [CTRL_W-1:0]         ctrl_o,
    output logic                      cnt_wr_en_o,
    output logic                      force_passive_o
);
    localparam int HI_W = CTRL_W - KEEP_LO;

    typedef struct packed {
        logic [HI_W-1:0] hi;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            ctrl_d.hi = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o          = {ctrl_q.hi, {KEEP_LO{1'b0}}};
    assign cnt_wr_en_o     = ctrl_o[BIT_TEST] & ctrl_o[BIT_CNTWR];
    assign force_passive_o = ctrl_o[BIT_TEST] & ctrl_o[BIT_FORCE];
endmodule

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
    parameter int CNT_W       = 8,
    parameter int BIG_STEP    = 8,
    parameter bit HAS_BUSOFF  = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_big_i,
    input  logic             step_one_i,
    input  logic             step_down_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W:0]   cnt_o
);
    localparam int          MAXV    = (1 << CNT_W) - 1;
    localparam int          SUM_W   = CNT_W + 2;
    localparam logic [CNT_W:0] SAT_VAL = HAS_BUSOFF ? (CNT_W+1)'(MAXV + 1)
                                                    : (CNT_W+1)'(MAXV);

    typedef struct packed {
        logic [CNT_W:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic frozen;
    logic [SUM_W-1:0] sum_big, sum_one;

    generate
        if (HAS_BUSOFF) begin : g_busoff
            assign frozen = cnt_q.cnt[CNT_W];
        end else begin : g_sat
            assign frozen = 1'b0;
        end
    endgenerate

    assign sum_big = {1'b0, cnt_q.cnt} + SUM_W'(BIG_STEP);
    assign sum_one = {1'b0, cnt_q.cnt} + SUM_W'(1);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.cnt = {1'b0, load_val_i};
        end else if (frozen) begin
            cnt_d = cnt_q;
        end else if (step_big_i) begin
            if (sum_big > SUM_W'(MAXV)) cnt_d.cnt = SAT_VAL;
            else                        cnt_d.cnt = sum_big[CNT_W:0];
        end else if (step_one_i) begin
            if (sum_one > SUM_W'(MAXV)) cnt_d.cnt = SAT_VAL;
            else                        cnt_d.cnt = sum_one[CNT_W:0];
        end else if (step_down_i && (cnt_q.cnt != '0)) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q.cnt;
endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PASSIVE_LIM = 128
) (
    input  logic [CNT_W:0] tec_i,
    input  logic [CNT_W:0] rec_i,
    input  logic           force_passive_i,
    output fc_state_e      state_o
);
    localparam logic [CNT_W:0] LIM = (CNT_W+1)'(PASSIVE_LIM);

    logic over_lim;

    always_comb begin
        over_lim = (tec_i >= LIM) || (rec_i >= LIM);
        if (tec_i[CNT_W])                   state_o = FC_BUSOFF;
        else if (over_lim || force_passive_i) state_o = FC_PASSIVE;
        else                                state_o = FC_ACTIVE;
    end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TX_STEP     = 8,
    parameter int RX_BIG_STEP = 8,
    parameter int PASSIVE_LIM = 128
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tx_err_i,
    input  logic              tx_ok_i,
    input  logic              rx_err1_i,
    input  logic              rx_err8_i,
    input  logic              rx_ok_i,
    input  logic              halt_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic [CNT_W:0]    tec_o,
    output logic [CNT_W-1:0]  rec_o,
    output logic              err_active_o,
    output logic              err_passive_o,
    output logic              bus_off_o
);
    localparam int PAD_W = CTRL_W - 2 * CNT_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic              cnt_wr_en, force_passive;
    logic              ctrl_wr, load_fire;
    logic [CNT_W:0]    tec_cnt, rec_cnt;
    logic [CNT_W-1:0]  tec_view;
    fc_state_e         state;
    reg_addr_e         addr;

    assign addr      = reg_addr_e'(reg_addr_i);
    assign ctrl_wr   = reg_wr_i && (addr == ADDR_CTRL);
    assign load_fire = reg_wr_i && (addr == ADDR_CNT) && cnt_wr_en && halt_i;

    can_fc_ctrl_reg #(
        .CTRL_W   (CTRL_W),
        .KEEP_LO  (KEEP_LO),
        .BIT_TEST (BIT_TEST),
        .BIT_CNTWR(BIT_CNTWR),
        .BIT_FORCE(BIT_FORCE)
    ) u_ctrl (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .wr_i           (ctrl_wr),
        .wdata_i        (reg_wdata_i[CTRL_W-1:KEEP_LO]),
        .ctrl_o         (ctrl_q),
        .cnt_wr_en_o    (cnt_wr_en),
        .force_passive_o(force_passive)
    );

    can_fc_counter #(
        .CNT_W     (CNT_W),
        .BIG_STEP  (TX_STEP),
        .HAS_BUSOFF(1'b1)
    ) u_tec (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_big_i (tx_err_i),
        .step_one_i (1'b0),
        .step_down_i(tx_ok_i),
        .load_i     (load_fire),
        .load_val_i (reg_wdata_i[CNT_W-1:0]),
        .cnt_o      (tec_cnt)
    );

    can_fc_counter #(
        .CNT_W     (CNT_W),
        .BIG_STEP  (RX_BIG_STEP),
        .HAS_BUSOFF(1'b0)
    ) u_rec (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_big_i (rx_err8_i),
        .step_one_i (rx_err1_i),
        .step_down_i(rx_ok_i),
        .load_i     (load_fire),
        .load_val_i (reg_wdata_i[CNT_W-1:0]),
        .cnt_o      (rec_cnt)
    );

    can_fc_state #(
        .CNT_W      (CNT_W),
        .PASSIVE_LIM(PASSIVE_LIM)
    ) u_state (
        .tec_i          (tec_cnt),
        .rec_i          (rec_cnt),
        .force_passive_i(force_passive),
        .state_o        (state)
    );

    assign tec_view = tec_cnt[CNT_W] ? {CNT_W{1'b1}} : tec_cnt[CNT_W-1:0];

    always_comb begin
        unique case (addr)
            ADDR_CTRL: reg_rdata_o = ctrl_q;
            ADDR_CNT:  reg_rdata_o = {{PAD_W{1'b0}}, rec_cnt[CNT_W-1:0], tec_view};
            default:   reg_rdata_o = '0;
        endcase
    end

    assign tec_o         = tec_cnt;
    assign rec_o         = rec_cnt[CNT_W-1:0];
    assign err_active_o  = (state == FC_ACTIVE);
    assign err_passive_o = (state == FC_PASSIVE);
    assign bus_off_o     = (state == FC_BUSOFF);
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tx_err_i,
    input logic             rx_err8_i,
    input logic             halt_i,
    input logic             reg_wr_i,
    input logic [1:0]       reg_addr_i,
    input logic [15:0]      reg_wdata_i,
    input logic [CNT_W:0]   tec_o,
    input logic [CNT_W-1:0] rec_o,
    input logic             err_active_o,
    input logic             err_passive_o,
    input logic             bus_off_o,
    input logic [15:0]      ctrl_q
);
    localparam logic [CNT_W:0]   TX_NEAR = (CNT_W+1)'((1 << CNT_W) - 8);
    localparam logic [CNT_W-1:0] RX_NEAR = CNT_W'((1 << CNT_W) - 8);
    localparam logic [CNT_W-1:0] RX_MAX  = {CNT_W{1'b1}};

    logic load_seen, force_seen;
    assign load_seen  = reg_wr_i && (reg_addr_i == 2'd1) && ctrl_q[15] && ctrl_q[14] && halt_i;
    assign force_seen = ctrl_q[15] && ctrl_q[13];

    assert_ctrl_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_wr_i && reg_addr_i == 2'd0) |=> $stable(ctrl_q));

    assert_ctrl_low_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_q[7:0] == 8'h00);

    assert_joint_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_seen |=> (tec_o == {1'b0, $past(reg_wdata_i[CNT_W-1:0])}) &&
                      (rec_o == $past(reg_wdata_i[CNT_W-1:0])));

    assert_load_no_busoff_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_seen |=> !bus_off_o);

    assert_force_passive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (force_seen && !bus_off_o) |-> err_passive_o);

    assert_tx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_seen && tx_err_i && tec_o < TX_NEAR) |=> tec_o == $past(tec_o) + 8);

    assert_busoff_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_off_o && !load_seen) |=> bus_off_o);

    assert_rx_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_seen && rx_err8_i && rec_o >= RX_NEAR) |=> rec_o == RX_MAX);

    assert_one_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({err_active_o, err_passive_o, bus_off_o}) == 1);
endmodule

bind can_fault_conf can_fault_conf_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_err_i     (tx_err_i),
    .rx_err8_i    (rx_err8_i),
    .halt_i       (halt_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .tec_o        (tec_o),
    .rec_o        (rec_o),
    .err_active_o (err_active_o),
    .err_passive_o(err_passive_o),
    .bus_off_o    (bus_off_o),
    .ctrl_q       (ctrl_q)
);

// File: tb/can_fault_conf_tb.sv
module can_fault_conf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_err = 0, tx_ok = 0, rx1 = 0, rx8 = 0, rxok = 0, halt = 0;
    logic        wr = 0;
    logic [1:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic [8:0]  tec;
    logic [7:0]  rec;
    logic        act, pas, bo;

    int  n_vec = 0, n_bad = 0;
    bit  done = 0;
    int  m_tec = 0, m_rec = 0;
    logic [15:0] m_ctrl = 16'h0;

    always #5 clk = ~clk;

    can_fault_conf u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .tx_err_i(tx_err), .tx_ok_i(tx_ok), .rx_err1_i(rx1), .rx_err8_i(rx8), .rx_ok_i(rxok),
        .halt_i(halt), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .tec_o(tec), .rec_o(rec),
        .err_active_o(act), .err_passive_o(pas), .bus_off_o(bo)
    );

    task automatic model_step();
        bit ld;
        ld = wr && addr == 2'd1 && m_ctrl[15] && m_ctrl[14] && halt;
        if (ld) begin
            m_tec = int'(wdata[7:0]);
            m_rec = int'(wdata[7:0]);
        end else begin
            if (m_tec != 256) begin
                if (tx_err)                   m_tec = (m_tec + 8 > 255) ? 256 : m_tec + 8;
                else if (tx_ok && m_tec > 0)  m_tec = m_tec - 1;
            end
            if (rx8)                          m_rec = (m_rec + 8 > 255) ? 255 : m_rec + 8;
            else if (rx1)                     m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
            else if (rxok && m_rec > 0)       m_rec = m_rec - 1;
        end
        if (wr && addr == 2'd0) m_ctrl = {wdata[15:8], 8'h00};
    endtask

    task automatic check(string tag);
        bit e_bo, e_pas, e_act, bad;
        logic [15:0] e_rd;
        e_bo  = (m_tec == 256);
        e_pas = !e_bo && ((m_ctrl[15] && m_ctrl[13]) || m_tec >= 128 || m_rec >= 128);
        e_act = !e_bo && !e_pas;
        case (addr)
            2'd0:    e_rd = m_ctrl;
            2'd1:    e_rd = {m_rec[7:0], e_bo ? 8'hFF : m_tec[7:0]};
            default: e_rd = 16'h0;
        endcase
        bad = 0;
        n_vec++;
        if (tec !== 9'(m_tec)) begin bad = 1;
            $display("FAIL %s tec act=%0d exp=%0d", tag, tec, m_tec); end
        if (rec !== 8'(m_rec)) begin bad = 1;
            $display("FAIL %s rec act=%0d exp=%0d", tag, rec, m_rec); end
        if ({act, pas, bo} !== {e_act, e_pas, e_bo}) begin bad = 1;
            $display("FAIL %s state act=%b exp=%b", tag, {act, pas, bo}, {e_act, e_pas, e_bo}); end
        if (rdata !== e_rd) begin bad = 1;
            $display("FAIL %s rdata act=%h exp=%h", tag, rdata, e_rd); end
        if (bad) n_bad++;
    endtask

    task automatic cyc(string tag, bit te, bit to, bit r1, bit r8, bit ro,
                       bit w, logic [1:0] a, logic [15:0] d);
        tx_err = te; tx_ok = to; rx1 = r1; rx8 = r8; rxok = ro;
        wr = w; addr = a; wdata = d;
        @(posedge clk);
        model_step();
        #1;
        check(tag);
    endtask

    task automatic ev(string tag, bit te, bit to, bit r1, bit r8, bit ro);
        cyc(tag, te, to, r1, r8, ro, 1'b0, 2'd1, 16'h0);
    endtask

    task automatic wreg(string tag, logic [1:0] a, logic [15:0] d);
        cyc(tag, 0, 0, 0, 0, 0, 1'b1, a, d);
    endtask

    task automatic load(string tag, logic [7:0] v);
        halt = 1;
        wreg(tag, 2'd0, 16'hC000);
        wreg(tag, 2'd1, {8'h00, v});
        wreg(tag, 2'd0, 16'h0000);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset");
        rst_n = 1'b1;
        #2;
        check("R1 reset");

        // R1: sweep every upper-byte value into the control register
        for (int v = 0; v < 256; v++) begin
            wreg("R1", 2'd0, {8'(v), 8'(v ^ 8'h5C)});
            ev("R1", 0, 0, 0, 0, 0);
            addr = 2'd0;
            #1; check("R1");
        end
        wreg("R1", 2'd0, 16'h0000);

        // R2: test bits 15..13 and halt, all combinations
        for (int c = 0; c < 8; c++) begin
            for (int h = 0; h < 2; h++) begin
                halt = h[0];
                wreg("R2", 2'd0, {3'(c), 13'h0});
                wreg("R2", 2'd1, 16'h0030 + 16'(c * 2 + h));
                ev("R2", 0, 0, 0, 0, 0);
                wreg("R2", 2'd0, 16'h0000);
                halt = 1; wreg("R2", 2'd0, 16'hC000);
                wreg("R2", 2'd1, 16'h0000);
                wreg("R2", 2'd0, 16'h0000);
            end
        end

        // R3: every loadable value, upper byte of data ignored
        halt = 1;
        wreg("R3", 2'd0, 16'hC000);
        for (int v = 0; v < 256; v++) begin
            wreg("R3", 2'd1, {8'hA5 ^ 8'(v), 8'(v)});
        end
        wreg("R3", 2'd0, 16'h0000);

        // R4: force bit with and without master enable
        load("R4", 8'd0);
        wreg("R4", 2'd0, 16'h2000); ev("R4", 0, 0, 0, 0, 0);
        wreg("R4", 2'd0, 16'hA000); ev("R4", 0, 0, 0, 0, 0);
        wreg("R4", 2'd0, 16'h8000); ev("R4", 0, 0, 0, 0, 0);
        wreg("R4", 2'd0, 16'h3F00); ev("R4", 0, 0, 0, 0, 0);
        wreg("R4", 2'd0, 16'h0000);

        // R5: transmit counter steps and floor
        load("R5", 8'd0);
        ev("R5", 0, 1, 0, 0, 0);
        ev("R5", 1, 0, 0, 0, 0);
        ev("R5", 1, 1, 0, 0, 0);
        for (int k = 0; k < 20; k++) ev("R5", 0, 1, 0, 0, 0);

        // R6: drive into bus off and keep poking
        load("R6", 8'd0);
        for (int k = 0; k < 33; k++) ev("R6", 1, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) ev("R6", 0, 1, 0, 0, 0);
        ev("R6", 0, 0, 0, 1, 0);
        ev("R6", 1, 1, 1, 0, 1);
        load("R6", 8'd255);
        ev("R6", 1, 0, 0, 0, 0);
        load("R3", 8'd248);
        ev("R6", 1, 0, 0, 0, 0);

        // R7: receive counter priority, saturation, floor
        load("R7", 8'd0);
        ev("R7", 0, 0, 0, 0, 1);
        for (int k = 0; k < 34; k++) ev("R7", 0, 0, 0, 1, 0);
        ev("R7", 0, 0, 1, 0, 0);
        ev("R7", 0, 0, 1, 1, 1);
        ev("R7", 0, 0, 1, 0, 1);
        for (int k = 0; k < 3; k++) ev("R7", 0, 0, 0, 0, 1);
        load("R7", 8'd250);
        ev("R7", 0, 0, 1, 0, 0);
        load("R7", 8'd2);
        for (int k = 0; k < 4; k++) ev("R7", 0, 0, 0, 0, 1);

        // R8: thresholds on each counter
        load("R8", 8'd127);
        ev("R8", 0, 0, 1, 0, 0);
        ev("R8", 0, 0, 0, 0, 1);
        ev("R8", 1, 0, 0, 0, 0);
        ev("R8", 0, 1, 0, 0, 0);
        load("R8", 8'd128);
        ev("R8", 0, 1, 0, 0, 1);

        // R9: load against same-cycle strobes
        halt = 1;
        wreg("R9", 2'd0, 16'hC000);
        cyc("R9", 1, 0, 0, 1, 0, 1'b1, 2'd1, 16'h0040);
        cyc("R9", 0, 1, 1, 0, 1, 1'b1, 2'd1, 16'h0081);
        wreg("R9", 2'd0, 16'h0000);

        // R10: reserved addresses
        wreg("R10", 2'd2, 16'hFFFF); wreg("R10", 2'd3, 16'hFFFF);
        ev("R10", 0, 0, 0, 0, 0);
        addr = 2'd0; #1; check("R10");

        // R8: mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            halt = lfsr[9];
            if (lfsr[15:12] == 4'h0)
                wreg("R8", 2'd0, {lfsr[7:0], 8'h00});
            else if (lfsr[15:12] == 4'h1)
                wreg("R8", 2'd1, lfsr);
            else
                cyc("R8", lfsr[0] & lfsr[5], lfsr[1], lfsr[2] & lfsr[6], lfsr[3] & lfsr[7] & lfsr[8],
                    lfsr[4], 1'b0, lfsr[11:10], 16'h0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule